// File: doc/BRIEF.md
# Auto-Increment Register Pointer Bank

This block is a bank of ten byte-wide locations placed behind a serial byte stream that an upstream controller has already decoded. The upstream logic reports the stream as single-cycle events: the start of a transaction, the register-address byte, each write-data byte and each read request, and the end of the transaction. The bank answers with an acknowledge for address and write bytes, and with read data for read requests.

The address byte selects a register and sets an auto-increment flag. The pointer then steps after each data byte. Reads wrap from the last location back to the first. Writes wrap to the first writable location, so a write burst never lands on the two input locations. Those two locations mirror a 16-bit external input port. A write aimed at them is acknowledged and then dropped.

Each event channel is a one-cycle strobe with no back-pressure, because the bank accepts every event in the cycle it arrives. `rd_valid_o` marks the cycle in which `rd_data_o` carries an accepted read. The source must keep strobes mutually exclusive.

Top module: `autoinc_reg_bank`

## Requirements
- R1: In the address byte, bit 4 is the auto-increment flag and bits 3..0 select the location. The byte is acknowledged only when bits 7..5 are all zero and the location is 9 or less.
- R2: Reset clears the pointer, the selection and every writable location to 0x00. A read before any accepted address byte returns 0x00 with `rd_valid_o` high.
- R3: A read returns the location at the current pointer in the same cycle as the request, with `rd_valid_o` high. Location 0 shows `in_pins_i[7:0]` and location 1 shows `in_pins_i[15:8]`, both taken at the moment of the read.
- R4: When auto-increment is on, each read advances the pointer, and location 9 is followed by location 0.
- R5: When auto-increment is on, each write advances the pointer, and location 9 is followed by location 2.
- R6: A write to location 0 or 1 is acknowledged, does not change what later reads of that location return, and still advances the pointer when auto-increment is on.
- R7: When auto-increment is off, repeated writes and reads all use the same location.
- R8: After a rejected address byte, write bytes are not acknowledged and not stored, and reads return 0x00. This lasts until the next accepted address byte.
- R9: A stop keeps the pointer, so reads in a later transaction continue from it. Address, write and read events outside a transaction are not acknowledged, store nothing and leave `rd_valid_o` low.
- R10: `ack_o` answers an address or write byte combinationally, in the same cycle as its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Transaction begins |
| stop_i | input | 1 | Transaction ends |
| addr_vld_i | input | 1 | `byte_i` holds the register-address byte |
| wr_vld_i | input | 1 | `byte_i` holds a write-data byte |
| byte_i | input | 8 | Address or write-data byte |
| rd_req_i | input | 1 | Request for one read byte |
| in_pins_i | input | 16 | Source of the two input locations |
| ack_o | output | 1 | Acknowledge for the current address or write byte |
| rd_valid_o | output | 1 | `rd_data_o` is valid for an accepted read |
| rd_data_o | output | 8 | Read data |

## Verification
The bench drives long bursts across the top of the map in both directions. A design that used a single wrap point would either write over the input locations or skip locations 0 and 1 on reads. It writes to the input locations and checks that reads still show the pins, and that the pointer still moves past them. A bank that stored the byte, or froze the pointer there, fails these checks. It sends address bytes with a high reserved bit and with an out-of-range location, checks that the following data is refused and that reads return zero, and drives events outside a transaction. These catch a decoder that ignores the reserved bits and a bank that ignores the transaction framing.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned NREG_DEF  = 10;
  localparam int unsigned RO_DEF    = 2;
  localparam int unsigned DW_DEF    = 8;
  localparam int unsigned PW_DEF    = 4;
  // address byte field layout
  localparam int unsigned AI_BIT    = 4;
  localparam int unsigned RSV_LO    = 5;
endpackage

// File: rtl/arb_ptr.sv
module arb_ptr
  import arb_pkg::*;
#(
  parameter int unsigned NREG   = NREG_DEF,
  parameter int unsigned RO_CNT = RO_DEF,
  parameter int unsigned PW     = PW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          addr_vld_i,
  input  logic [7:0]    addr_byte_i,
  input  logic          wr_vld_i,
  input  logic          rd_req_i,
  output logic [PW-1:0] ptr_o,
  output logic          sel_ok_o,
  output logic          in_txn_o,
  output logic          addr_ok_o
);
  localparam logic [PW-1:0] LAST  = PW'(NREG - 1);
  localparam logic [PW-1:0] WFIRST = PW'(RO_CNT);

  logic [PW-1:0] ptr_q;
  logic          ai_q, sel_q, txn_q;
  logic          step;

  assign addr_ok_o = (addr_byte_i[7:RSV_LO] == '0) && (addr_byte_i[PW-1:0] <= LAST);
  assign step      = txn_q && sel_q && ai_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ai_q  <= 1'b0;
      sel_q <= 1'b0;
      txn_q <= 1'b0;
    end else begin
      if (start_i)     txn_q <= 1'b1;
      else if (stop_i) txn_q <= 1'b0;

      if (txn_q && addr_vld_i) begin
        sel_q <= addr_ok_o;
        if (addr_ok_o) begin
          ptr_q <= addr_byte_i[PW-1:0];
          ai_q  <= addr_byte_i[AI_BIT];
        end
      end else if (step && wr_vld_i) begin
        ptr_q <= (ptr_q == LAST) ? WFIRST : ptr_q + 1'b1;
      end else if (step && rd_req_i) begin
        ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  assign ptr_o    = ptr_q;
  assign sel_ok_o = sel_q;
  assign in_txn_o = txn_q;

  // R5
  wr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !addr_vld_i && wr_vld_i && ptr_q == LAST) |=> (ptr_q == WFIRST));
  // R4
  rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !addr_vld_i && !wr_vld_i && rd_req_i && ptr_q == LAST) |=> (ptr_q == '0));
  // R7
  hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ai_q && !addr_vld_i && (wr_vld_i || rd_req_i)) |=> $stable(ptr_q));
  // R8
  nosel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && !addr_vld_i) |=> $stable(ptr_q));
endmodule

// File: rtl/arb_regs.sv
module arb_regs
  import arb_pkg::*;
#(
  parameter int unsigned NREG   = NREG_DEF,
  parameter int unsigned RO_CNT = RO_DEF,
  parameter int unsigned DW     = DW_DEF,
  parameter int unsigned PW     = PW_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [PW-1:0]        ptr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [RO_CNT*DW-1:0] ext_i,
  output logic [DW-1:0]        rdata_o
);
  logic [NREG-1:RO_CNT][DW-1:0] store_q;
  logic [DW-1:0]                loc [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_loc
    if (g < RO_CNT) begin : g_ro
      assign loc[g] = ext_i[g*DW +: DW];
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)                           store_q[g] <= '0;
        else if (we_i && ptr_i == PW'(g))     store_q[g] <= wdata_i;
      end
      assign loc[g] = store_q[g];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++)
      if (ptr_i == PW'(i)) rdata_o = loc[i];
  end

  // R6
  ro_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && ptr_i < PW'(RO_CNT)) |=> $stable(store_q));
  // R5
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && ptr_i >= PW'(RO_CNT) && ptr_i < PW'(NREG)) |=> (rdata_o == $past(wdata_i) || ptr_i != $past(ptr_i)));
endmodule

// File: rtl/autoinc_reg_bank.sv
module autoinc_reg_bank
  import arb_pkg::*;
#(
  parameter int unsigned NREG   = NREG_DEF,
  parameter int unsigned RO_CNT = RO_DEF,
  parameter int unsigned DW     = DW_DEF,
  parameter int unsigned PW     = PW_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 addr_vld_i,
  input  logic                 wr_vld_i,
  input  logic [7:0]           byte_i,
  input  logic                 rd_req_i,
  input  logic [RO_CNT*DW-1:0] in_pins_i,
  output logic                 ack_o,
  output logic                 rd_valid_o,
  output logic [DW-1:0]        rd_data_o
);
  logic [PW-1:0] ptr;
  logic          sel_ok, in_txn, addr_ok;
  logic [DW-1:0] mux_data;

  arb_ptr #(.NREG(NREG), .RO_CNT(RO_CNT), .PW(PW)) u_ptr (
    .clk, .rst_n, .start_i, .stop_i, .addr_vld_i,
    .addr_byte_i(byte_i), .wr_vld_i, .rd_req_i,
    .ptr_o(ptr), .sel_ok_o(sel_ok), .in_txn_o(in_txn), .addr_ok_o(addr_ok)
  );

  arb_regs #(.NREG(NREG), .RO_CNT(RO_CNT), .DW(DW), .PW(PW)) u_regs (
    .clk, .rst_n,
    .we_i(in_txn && sel_ok && wr_vld_i && !addr_vld_i),
    .ptr_i(ptr), .wdata_i(byte_i[DW-1:0]), .ext_i(in_pins_i),
    .rdata_o(mux_data)
  );

  assign ack_o      = in_txn && ((addr_vld_i && addr_ok) || (wr_vld_i && sel_ok));
  assign rd_valid_o = in_txn && rd_req_i;
  assign rd_data_o  = (rd_valid_o && sel_ok) ? mux_data : '0;

  // R1
  rsv_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld_i && byte_i[7:RSV_LO] != '0) |-> !ack_o);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_txn |-> (!ack_o && !rd_valid_o));
  // R8
  nosel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok && rd_req_i) |-> (rd_data_o == '0));
endmodule

// File: tb/autoinc_reg_bank_tb_top.sv
`timescale 1ns/1ps
module autoinc_reg_bank_tb_top;
  logic clk = 0, rst_n = 0;
  logic start_i = 0, stop_i = 0, addr_vld_i = 0, wr_vld_i = 0, rd_req_i = 0;
  logic [7:0]  byte_i = '0;
  logic [15:0] in_pins_i = 16'hB7A5;
  logic ack_o, rd_valid_o;
  logic [7:0] rd_data_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  autoinc_reg_bank dut_i (.*);

  // op: 0 start, 1 addr, 2 write, 3 read, 4 stop
  // {req[3:0], op[2:0], byte[7:0], ack, exp_data[7:0]}
  localparam int NV = 38;
  localparam logic [23:0] TBL [NV] = '{
    {4'd9, 3'd0, 8'h00, 1'b0, 8'h00},
    {4'd1, 3'd1, 8'h12, 1'b1, 8'h00},  // R1 ai, loc2
    {4'd5, 3'd2, 8'h11, 1'b1, 8'h00},
    {4'd5, 3'd2, 8'h22, 1'b1, 8'h00},
    {4'd5, 3'd2, 8'h33, 1'b1, 8'h00},
    {4'd1, 3'd1, 8'h18, 1'b1, 8'h00},
    {4'd5, 3'd2, 8'h88, 1'b1, 8'h00},
    {4'd5, 3'd2, 8'h99, 1'b1, 8'h00},
    {4'd5, 3'd2, 8'hC2, 1'b1, 8'h00},  // R5 wrap to 2
    {4'd9, 3'd4, 8'h00, 1'b0, 8'h00},
    {4'd9, 3'd0, 8'h00, 1'b0, 8'h00},
    {4'd9, 3'd3, 8'h00, 1'b0, 8'h22},  // R9 pointer kept
    {4'd4, 3'd3, 8'h00, 1'b0, 8'h33},
    {4'd1, 3'd1, 8'h18, 1'b1, 8'h00},
    {4'd4, 3'd3, 8'h00, 1'b0, 8'h88},
    {4'd4, 3'd3, 8'h00, 1'b0, 8'h99},
    {4'd4, 3'd3, 8'h00, 1'b0, 8'hA5},  // R4 wrap to 0
    {4'd3, 3'd3, 8'h00, 1'b0, 8'hB7},
    {4'd5, 3'd3, 8'h00, 1'b0, 8'hC2},
    {4'd1, 3'd1, 8'h05, 1'b1, 8'h00},  // R7 no ai
    {4'd7, 3'd2, 8'h55, 1'b1, 8'h00},
    {4'd7, 3'd2, 8'h56, 1'b1, 8'h00},
    {4'd7, 3'd3, 8'h00, 1'b0, 8'h56},
    {4'd7, 3'd3, 8'h00, 1'b0, 8'h56},
    {4'd1, 3'd1, 8'h11, 1'b1, 8'h00},
    {4'd6, 3'd2, 8'hEE, 1'b1, 8'h00},  // R6 dropped
    {4'd6, 3'd2, 8'h44, 1'b1, 8'h00},  // R6 pointer moved to 2
    {4'd1, 3'd1, 8'h10, 1'b1, 8'h00},
    {4'd6, 3'd3, 8'h00, 1'b0, 8'hA5},
    {4'd6, 3'd3, 8'h00, 1'b0, 8'hB7},
    {4'd6, 3'd3, 8'h00, 1'b0, 8'h44},
    {4'd1, 3'd1, 8'h1A, 1'b0, 8'h00},  // R1 loc 10
    {4'd8, 3'd2, 8'h77, 1'b0, 8'h00},
    {4'd8, 3'd3, 8'h00, 1'b0, 8'h00},
    {4'd1, 3'd1, 8'h20, 1'b0, 8'h00},  // R1 reserved bit
    {4'd8, 3'd3, 8'h00, 1'b0, 8'h00},
    {4'd1, 3'd1, 8'h0F, 1'b0, 8'h00},
    {4'd9, 3'd4, 8'h00, 1'b0, 8'h00}
  };

  logic s_ack, s_rdv;
  logic [7:0] s_rd;

  task automatic apply(input int op, input logic [7:0] b);
    @(negedge clk);
    start_i = (op == 0); addr_vld_i = (op == 1); wr_vld_i = (op == 2);
    rd_req_i = (op == 3); stop_i = (op == 4); byte_i = b;
    #1;
    s_ack = ack_o; s_rdv = rd_valid_o; s_rd = rd_data_o;
    @(posedge clk); #1;
    start_i = 0; addr_vld_i = 0; wr_vld_i = 0; rd_req_i = 0; stop_i = 0;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic v, input logic [7:0] d);
    apply(3, 8'h00);
    chk(req, {7'd0, s_rdv, s_rd}, {7'd0, v, d});
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    // R2 reset state
    #1; chk("R2", {15'd0, ack_o}, 16'd0);
    apply(0, 8'h00);
    rd_chk("R2", 1'b1, 8'h00);
    apply(4, 8'h00);

    for (int i = 0; i < NV; i++) begin
      int op;
      op = int'(TBL[i][19:17]);
      apply(op, TBL[i][16:9]);
      if (op == 1 || op == 2)
        chk($sformatf("R%0d (ack) row %0d", TBL[i][23:20], i), {15'd0, s_ack}, {15'd0, TBL[i][8]});
      else if (op == 3)
        chk($sformatf("R%0d (rd) row %0d", TBL[i][23:20], i), {7'd0, s_rdv, s_rd}, {8'h01, TBL[i][7:0]});
    end

    // R9 events outside a transaction
    apply(1, 8'h12); chk("R9", {15'd0, s_ack}, 16'd0);
    apply(2, 8'h5A); chk("R9", {15'd0, s_ack}, 16'd0);
    rd_chk("R9", 1'b0, 8'h00);
    apply(0, 8'h00);
    apply(1, 8'h02); chk("R10", {15'd0, s_ack}, 16'd1);
    rd_chk("R9", 1'b1, 8'h44);

    // R3 pins taken at read time
    in_pins_i = 16'h3C69;
    apply(1, 8'h10);
    rd_chk("R3", 1'b1, 8'h69);
    rd_chk("R3", 1'b1, 8'h3C);

    // R6 write to loc0 with ai off
    apply(1, 8'h00);
    apply(2, 8'h5A); chk("R6", {15'd0, s_ack}, 16'd1);
    rd_chk("R6", 1'b1, 8'h69);
    rd_chk("R7", 1'b1, 8'h69);
    apply(4, 8'h00);

    // R2 writable locations cleared by reset
    @(negedge clk); rst_n = 0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1;
    apply(0, 8'h00);
    apply(1, 8'h12);
    for (int k = 2; k < 10; k++) rd_chk("R2", 1'b1, 8'h00);
    apply(4, 8'h00);

    done = 1;
    summary();
  end
endmodule